// File: doc/BRIEF.md
# Indexed register window

This block is the register window a host sees on a network controller. The aperture is 32 bytes. It holds an index pointer, a data port into the control/status bank, a data port into the configuration bank and a port that resets the controller when it is read. The host writes an index into the pointer. The next access to either data port then reaches the 16-bit register at that index in the chosen bank. Reading the pointer returns the index, so software can write a known value, read it back and learn which layout is active.

Two aperture layouts exist. After reset the window uses the word layout. The first 32-bit write to offset 0x10 moves it to the doubleword layout, and it stays there until the next reset. Behind the window there are three modelled registers: a command/status register at index 0, a two-part chip identifier, and a software-structure-size selector in the configuration bank. Each bank also has a small generic array of plain read/write registers. The host access is a single-cycle request. Read data is combinational in the request cycle, and writes and read side effects take place at the clock edge that ends the request.

Top module: `regwin_port`

## Requirements
- R1: A low level on rst_n, or a read of the reset port in the active layout, returns all state to its reset value at that clock edge. The layout becomes word, the pointer becomes 0, command register index 0 reads 0x0004, and the selector and all generic registers read 0. A read of the reset port returns 0.
- R2: In the word layout the offsets are: 0x10 status data port, 0x12 pointer, 0x14 reset port, 0x16 configuration data port.
- R3: A write with acc_wide=1 at offset 0x10 sets wide_layout=1. That same write goes to the status data port. After it the offsets are: 0x10 status data, 0x14 pointer, 0x18 reset, 0x1C configuration data. The word-only offsets 0x12 and 0x16 then read 0, and 16-bit accesses do not clear the mode.
- R4: The pointer stores the low IDX_W (7) bits of a write and reads back zero-extended. Writing 88 reads 88, and writing 200 reads 72.
- R5: Read data carries the register value in bits 15:0, with bits 31:16 zero. Only bits 15:0 of a data-port write are used.
- R6: Status index 88 reads {PART_CODE[3:0],12'h003} and index 89 reads {4'h0,PART_CODE[15:4]}. Together they form a 32-bit identifier whose bits 11:0 are 0x003 and whose bits 27:12 are PART_CODE. The default PART_CODE is 0x2627, so the reads are 0x7003 and 0x0262.
- R7: In status index 0, bit 0 is init, bit 1 is start, bit 2 is stop, bit 3 is transmit demand, bit 6 is interrupt enable and bit 8 is init-done. A write with bit 2 set forces 0x0004 whatever else it carries. Writing 1 to bit 0 or bit 1 sets that bit and clears stop. Writing 0 to bits 0 to 3 has no effect. Bit 6 takes the written value.
- R8: After init is set, the following clock edge clears init and sets init-done. Writing 1 to bit 8 clears init-done, and writing 0 to it has no effect.
- R9: Transmit demand reads 1 in the cycle after it is written and 0 from the next cycle on.
- R10: Configuration index 20 is a read/write selector. sw_struct32 equals its bit 1, so writing 2 gives 1 and writing 4 gives 0.
- R11: An unimplemented index in either bank reads 0 and ignores writes. Offsets outside the active layout read 0 and ignore writes.
- R12: Status indices 16..23 and configuration indices 0..7 are independent 16-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | Access is 32 bits wide |
| acc_off | input | 5 | Byte offset within the aperture |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the request cycle |
| wide_layout | output | 1 | Doubleword layout is active |
| sw_struct32 | output | 1 | 32-bit software structures selected |

## Verification
The hardest state to reach is the doubleword layout after a port-triggered reset. It can only be entered by one specific 32-bit write, and it can only be left by reading an offset whose meaning changes with the layout. The stimulus first reaches every bank through the word layout. It then switches with a wide write that also carries a command, checks that the old offsets read dead, and resets through 0x18. After that it shows that the word offsets are live again and that every register has cleared. The one-cycle init and transmit-demand transitions are checked by reading status index 0 in the two cycles that follow the write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int OFF_W = 5;

    localparam logic [OFF_W-1:0] OFF_CSR   = 5'h10;
    localparam logic [OFF_W-1:0] OFF_W_PTR = 5'h12;
    localparam logic [OFF_W-1:0] OFF_W_RST = 5'h14;
    localparam logic [OFF_W-1:0] OFF_W_BCR = 5'h16;
    localparam logic [OFF_W-1:0] OFF_D_PTR = 5'h14;
    localparam logic [OFF_W-1:0] OFF_D_RST = 5'h18;
    localparam logic [OFF_W-1:0] OFF_D_BCR = 5'h1C;

    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_IENA  = 6;
    localparam int B_IDON  = 8;

    localparam int IDX_ID_LO  = 88;
    localparam int IDX_ID_HI  = 89;
    localparam int IDX_SWSEL  = 20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CSR,
        SEL_PTR,
        SEL_RST,
        SEL_BCR
    } port_sel_e;

    typedef struct packed {
        logic init;
        logic start;
        logic stop;
        logic tdmd;
        logic iena;
        logic idon;
    } cmd_t;

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
(
    input  logic             wide,
    input  logic [OFF_W-1:0] off,
    output port_sel_e        sel
);
    always_comb begin
        sel = SEL_NONE;
        if (off == OFF_CSR) begin
            sel = SEL_CSR;
        end else if (wide) begin
            case (off)
                OFF_D_PTR: sel = SEL_PTR;
                OFF_D_RST: sel = SEL_RST;
                OFF_D_BCR: sel = SEL_BCR;
                default:   sel = SEL_NONE;
            endcase
        end else begin
            case (off)
                OFF_W_PTR: sel = SEL_PTR;
                OFF_W_RST: sel = SEL_RST;
                OFF_W_BCR: sel = SEL_BCR;
                default:   sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/regwin_cmd.sv
module regwin_cmd
    import regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] rdval
);
    localparam cmd_t CMD_RESET = '{init: 1'b0, start: 1'b0, stop: 1'b1,
                                   tdmd: 1'b0, iena: 1'b0, idon: 1'b0};

    cmd_t cmd_q, cmd_d;
    logic wdata_unused;

    assign wdata_unused = ^{wdata[15:9], wdata[7], wdata[5:4]};

    always_comb begin
        cmd_d = cmd_q;
        // autonomous progress first: init completes, demand is a pulse
        if (cmd_q.init) begin
            cmd_d.init = 1'b0;
            cmd_d.idon = 1'b1;
        end
        cmd_d.tdmd = 1'b0;
        if (clr) begin
            cmd_d = CMD_RESET;
        end else if (we) begin
            if (wdata[B_STOP]) begin
                cmd_d = CMD_RESET;
            end else begin
                cmd_d.iena = wdata[B_IENA];
                if (wdata[B_IDON])  cmd_d.idon = 1'b0;
                if (wdata[B_INIT])  begin cmd_d.init  = 1'b1; cmd_d.stop = 1'b0; end
                if (wdata[B_START]) begin cmd_d.start = 1'b1; cmd_d.stop = 1'b0; end
                if (wdata[B_TDMD])  cmd_d.tdmd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= CMD_RESET;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        rdval          = '0;
        rdval[B_INIT]  = cmd_q.init;
        rdval[B_START] = cmd_q.start;
        rdval[B_STOP]  = cmd_q.stop;
        rdval[B_TDMD]  = cmd_q.tdmd;
        rdval[B_IENA]  = cmd_q.iena;
        rdval[B_IDON]  = cmd_q.idon;
    end

    p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[B_STOP]) |=> (rdval == 16'h0004));

    p_idon_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.init && !clr && !(we && (wdata[B_STOP] || wdata[B_IDON])))
        |=> cmd_q.idon);

    p_tdmd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.tdmd && !(we && wdata[B_TDMD])) |=> !cmd_q.tdmd);
endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile
    import regwin_pkg::*;
#(
    parameter int          IDX_W     = 7,
    parameter int          CGEN_BASE = 16,
    parameter int          CGEN_N    = 8,
    parameter int          BGEN_BASE = 0,
    parameter int          BGEN_N    = 8,
    parameter logic [15:0] PART_CODE = 16'h2627
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W-1:0] idx,
    input  logic             csr_we,
    input  logic             bcr_we,
    input  logic [15:0]      wdata,
    output logic [15:0]      csr_rd,
    output logic [15:0]      bcr_rd,
    output logic             struct32
);
    typedef struct packed {
        logic [CGEN_N-1:0][15:0] cgen;
        logic [BGEN_N-1:0][15:0] bgen;
        logic [15:0]             swsel;
    } rf_t;

    rf_t rf_q, rf_d;
    int  idx_i;
    logic [CGEN_N-1:0] c_hit;
    logic [BGEN_N-1:0] b_hit;
    logic sel_hit;

    assign idx_i   = 32'(idx);
    assign sel_hit = (idx_i == IDX_SWSEL);

    for (genvar g = 0; g < CGEN_N; g++) begin : g_chit
        assign c_hit[g] = (idx_i == CGEN_BASE + g);
    end
    for (genvar g = 0; g < BGEN_N; g++) begin : g_bhit
        assign b_hit[g] = (idx_i == BGEN_BASE + g);
    end

    always_comb begin
        rf_d = rf_q;
        if (clr) begin
            rf_d = '0;
        end else begin
            for (int i = 0; i < CGEN_N; i++)
                if (csr_we && c_hit[i]) rf_d.cgen[i] = wdata;
            for (int i = 0; i < BGEN_N; i++)
                if (bcr_we && b_hit[i]) rf_d.bgen[i] = wdata;
            if (bcr_we && sel_hit) rf_d.swsel = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        csr_rd = '0;
        for (int i = 0; i < CGEN_N; i++)
            if (c_hit[i]) csr_rd = rf_q.cgen[i];
        if (idx_i == IDX_ID_LO) csr_rd = {PART_CODE[3:0], 12'h003};
        if (idx_i == IDX_ID_HI) csr_rd = {4'h0, PART_CODE[15:4]};
        bcr_rd = '0;
        for (int i = 0; i < BGEN_N; i++)
            if (b_hit[i]) bcr_rd = rf_q.bgen[i];
        if (sel_hit) bcr_rd = rf_q.swsel;
    end

    assign struct32 = rf_q.swsel[1];

    p_swsel_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bcr_we && sel_hit && !clr) |=> (struct32 == $past(wdata[1])));
endmodule

// File: rtl/regwin_port.sv
module regwin_port
    import regwin_pkg::*;
#(
    parameter int          IDX_W     = 7,
    parameter int          CGEN_BASE = 16,
    parameter int          CGEN_N    = 8,
    parameter int          BGEN_BASE = 0,
    parameter int          BGEN_N    = 8,
    parameter logic [15:0] PART_CODE = 16'h2627
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic        acc_wide,
    input  logic [4:0]  acc_off,
    input  logic [31:0] acc_wdata,
    output logic [31:0] rd_data,
    output logic        wide_layout,
    output logic        sw_struct32
);
    typedef struct packed {
        logic             wide;
        logic [IDX_W-1:0] ptr;
    } win_t;

    win_t      win_q, win_d;
    port_sel_e sel;
    logic      rd, wr, clr, cmd_we, csr_we, bcr_we, switch_req;
    logic [15:0] cmd_rd, csr_rd, bcr_rd;
    logic      wdata_hi_unused;

    assign wdata_hi_unused = ^acc_wdata[31:16];

    regwin_decode u_dec (
        .wide (win_q.wide),
        .off  (acc_off),
        .sel  (sel)
    );

    assign rd         = acc_en && !acc_wr;
    assign wr         = acc_en && acc_wr;
    assign clr        = rd && (sel == SEL_RST);
    assign switch_req = wr && acc_wide && (acc_off == OFF_CSR);
    assign csr_we     = wr && (sel == SEL_CSR);
    assign cmd_we     = csr_we && (win_q.ptr == '0);
    assign bcr_we     = wr && (sel == SEL_BCR);

    regwin_cmd u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .we    (cmd_we),
        .wdata (acc_wdata[15:0]),
        .rdval (cmd_rd)
    );

    regwin_regfile #(
        .IDX_W     (IDX_W),
        .CGEN_BASE (CGEN_BASE),
        .CGEN_N    (CGEN_N),
        .BGEN_BASE (BGEN_BASE),
        .BGEN_N    (BGEN_N),
        .PART_CODE (PART_CODE)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .idx      (win_q.ptr),
        .csr_we   (csr_we),
        .bcr_we   (bcr_we),
        .wdata    (acc_wdata[15:0]),
        .csr_rd   (csr_rd),
        .bcr_rd   (bcr_rd),
        .struct32 (sw_struct32)
    );

    always_comb begin
        win_d = win_q;
        if (clr) begin
            win_d = '0;
        end else begin
            if (switch_req)                win_d.wide = 1'b1;
            if (wr && (sel == SEL_PTR))    win_d.ptr  = acc_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd) begin
            case (sel)
                SEL_CSR: rd_data[15:0] = (win_q.ptr == '0) ? cmd_rd : csr_rd;
                SEL_PTR: rd_data[15:0] = 16'(win_q.ptr);
                SEL_BCR: rd_data[15:0] = bcr_rd;
                default: rd_data       = '0;
            endcase
        end
    end

    assign wide_layout = win_q.wide;

    p_layout_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_q.wide) |-> $past(acc_en && acc_wr && acc_wide && acc_off == OFF_CSR));

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && sel == SEL_PTR) && !clr) |=> $stable(win_q.ptr));

    p_port_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!win_q.wide && win_q.ptr == '0 && cmd_rd == 16'h0004));
endmodule

// File: tb/sim_regwin_port.sv
module sim_regwin_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_wide = 1'b0;
    logic [4:0]  acc_off = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic        wide_layout, sw_struct32;

    int checks = 0, failures = 0, cyc = 0;
    string phase = "R1";

    localparam int CG_BASE = 16, NG = 8, BG_BASE = 0;
    localparam bit [15:0] PART = 16'h2627;

    regwin_port u0 (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .wide_layout(wide_layout), .sw_struct32(sw_struct32));

    always #2 clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit        m_wide;
    int        m_ptr;
    bit [15:0] m_cmd, m_sel;
    bit [15:0] m_cg[NG];
    bit [15:0] m_bg[NG];

    task automatic m_reset();
        m_wide = 0; m_ptr = 0; m_cmd = 16'h0004; m_sel = 0;
        for (int i = 0; i < NG; i++) begin m_cg[i] = 0; m_bg[i] = 0; end
    endtask

    // 0 none, 1 status data, 2 pointer, 3 reset, 4 config data
    function automatic int port_of(bit w, int off);
        if (off == 16) return 1;
        if (!w) return (off == 18) ? 2 : (off == 20) ? 3 : (off == 22) ? 4 : 0;
        return (off == 20) ? 2 : (off == 24) ? 3 : (off == 28) ? 4 : 0;
    endfunction

    function automatic bit [15:0] exp_rd(int off);
        int p = port_of(m_wide, off);
        if (p == 2) return 16'(m_ptr);
        if (p == 1) begin
            if (m_ptr == 0) return m_cmd;
            if (m_ptr == 88) return {PART[3:0], 12'h003};
            if (m_ptr == 89) return {4'h0, PART[15:4]};
            if (m_ptr >= CG_BASE && m_ptr < CG_BASE + NG) return m_cg[m_ptr - CG_BASE];
            return 0;
        end
        if (p == 4) begin
            if (m_ptr == 20) return m_sel;
            if (m_ptr >= BG_BASE && m_ptr < BG_BASE + NG) return m_bg[m_ptr - BG_BASE];
            return 0;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int p;
        bit [15:0] d;
        cyc++;
        if (!rst_n) m_reset();
        else begin
            p = port_of(m_wide, acc_off);
            d = acc_wdata[15:0];
            if (acc_en && !acc_wr && p == 3) m_reset();
            else begin
                if (m_cmd[0]) begin m_cmd[0] = 0; m_cmd[8] = 1; end
                m_cmd[3] = 0;
                if (acc_en && acc_wr) begin
                    if (acc_wide && acc_off == 16) m_wide = 1;
                    if (p == 2) m_ptr = acc_wdata & 127;
                    if (p == 1) begin
                        if (m_ptr == 0) begin
                            if (d[2]) m_cmd = 16'h0004;
                            else begin
                                m_cmd[6] = d[6];
                                if (d[8]) m_cmd[8] = 0;
                                if (d[0]) begin m_cmd[0] = 1; m_cmd[2] = 0; end
                                if (d[1]) begin m_cmd[1] = 1; m_cmd[2] = 0; end
                                if (d[3]) m_cmd[3] = 1;
                            end
                        end else if (m_ptr >= CG_BASE && m_ptr < CG_BASE + NG)
                            m_cg[m_ptr - CG_BASE] = d;
                    end
                    if (p == 4) begin
                        if (m_ptr == 20) m_sel = d;
                        else if (m_ptr >= BG_BASE && m_ptr < BG_BASE + NG)
                            m_bg[m_ptr - BG_BASE] = d;
                    end
                end
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        check(rd_data, (acc_en && !acc_wr) ? {16'h0, exp_rd(acc_off)} : 32'h0,
              {phase, " model rd_data"});
        check({31'h0, wide_layout}, {31'h0, m_wide}, "R3 model wide_layout");
        check({31'h0, sw_struct32}, {31'h0, m_sel[1]}, "R10 model sw_struct32");
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(input bit w, input bit wd, input bit [4:0] o, input bit [31:0] d);
        @(negedge clk);
        acc_en = 1; acc_wr = w; acc_wide = wd; acc_off = o; acc_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_wide = 0;
    endtask

    task automatic rchk(input bit wd, input bit [4:0] o, input bit [31:0] exp, input string tag);
        acc(0, wd, o, 0);
        #1;
        check(rd_data, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R1";
        rchk(0, 5'h10, 32'h0004, "R1 status index 0 after reset");
        rchk(0, 5'h12, 32'h0, "R1 pointer after reset");

        phase = "R4";
        acc(1, 0, 5'h12, 88);
        rchk(0, 5'h12, 32'd88, "R4 pointer readback 88");
        acc(1, 0, 5'h12, 200);
        rchk(0, 5'h12, 32'd72, "R4 pointer keeps low bits");

        phase = "R6";
        acc(1, 0, 5'h12, 88);
        rchk(0, 5'h10, 32'h7003, "R6 identifier low");
        acc(1, 0, 5'h12, 89);
        rchk(0, 5'h10, 32'h0262, "R6 identifier high");

        phase = "R2";
        acc(1, 0, 5'h12, 20);
        acc(1, 0, 5'h16, 2);
        idle(); #1;
        check({31'h0, sw_struct32}, 1, "R10 selector 2 gives 32-bit");
        rchk(0, 5'h16, 32'h2, "R2 config port at 0x16");
        acc(1, 0, 5'h16, 4);
        rchk(0, 5'h16, 32'h4, "R2 config readback 4");
        check({31'h0, sw_struct32}, 0, "R10 selector 4 gives 16-bit");

        phase = "R12";
        acc(1, 0, 5'h12, 17);
        acc(1, 0, 5'h10, 16'hBEEF);
        rchk(0, 5'h10, 32'hBEEF, "R12 status generic");
        acc(1, 0, 5'h12, 3);
        acc(1, 0, 5'h16, 16'h1234);
        rchk(0, 5'h16, 32'h1234, "R12 config generic");
        rchk(0, 5'h10, 32'h0, "R12 status index 3 unimplemented");

        phase = "R11";
        acc(1, 0, 5'h12, 40);
        acc(1, 0, 5'h10, 16'h5555);
        rchk(0, 5'h10, 32'h0, "R11 unimplemented status index");
        acc(1, 0, 5'h16, 16'h5555);
        rchk(0, 5'h16, 32'h0, "R11 unimplemented config index");
        rchk(0, 5'h18, 32'h0, "R11 unmapped word offset");
        acc(1, 0, 5'h08, 16'h1111);
        rchk(0, 5'h12, 32'd40, "R11 unmapped write ignored");
        acc(1, 0, 5'h12, 17);
        rchk(0, 5'h10, 32'hBEEF, "R11 generic untouched");

        phase = "R7";
        acc(1, 0, 5'h12, 0);
        acc(1, 0, 5'h10, 16'h0042);
        rchk(0, 5'h10, 32'h0042, "R7 start and enable");
        acc(1, 0, 5'h10, 16'h0000);
        rchk(0, 5'h10, 32'h0002, "R7 zero write keeps start");
        acc(1, 0, 5'h10, 16'h0046);
        rchk(0, 5'h10, 32'h0004, "R7 stop over start");

        phase = "R8";
        acc(1, 0, 5'h10, 16'h0001);
        rchk(0, 5'h10, 32'h0001, "R8 init visible");
        rchk(0, 5'h10, 32'h0100, "R8 init done");
        acc(1, 0, 5'h10, 16'h0000);
        rchk(0, 5'h10, 32'h0100, "R8 zero keeps done");
        acc(1, 0, 5'h10, 16'h0100);
        rchk(0, 5'h10, 32'h0000, "R8 one clears done");

        phase = "R9";
        acc(1, 0, 5'h10, 16'h0048);
        rchk(0, 5'h10, 32'h0048, "R9 demand visible");
        rchk(0, 5'h10, 32'h0040, "R9 demand cleared");

        phase = "R3";
        acc(1, 1, 5'h10, 32'hFFFF_0002);
        rchk(1, 5'h10, 32'h0000_0002, "R5 wide write low half only");
        check({31'h0, wide_layout}, 1, "R3 layout switched");
        acc(1, 1, 5'h14, 32'hABCD_0059);
        rchk(1, 5'h14, 32'h59, "R3 pointer at 0x14");
        rchk(1, 5'h10, 32'h0262, "R3 status via new pointer");
        rchk(0, 5'h12, 32'h0, "R3 word pointer offset dead");
        acc(1, 1, 5'h14, 20);
        acc(1, 1, 5'h1C, 2);
        rchk(1, 5'h1C, 32'h2, "R3 config at 0x1C");
        rchk(0, 5'h16, 32'h0, "R3 word config offset dead");
        acc(1, 0, 5'h10, 16'h0000);
        idle(); #1;
        check({31'h0, wide_layout}, 1, "R3 layout sticky");

        phase = "R1";
        rchk(1, 5'h18, 32'h0, "R1 reset port reads 0");
        idle(); #1;
        check({31'h0, wide_layout}, 0, "R1 layout back to word");
        check({31'h0, sw_struct32}, 0, "R1 selector cleared");
        rchk(0, 5'h10, 32'h0004, "R1 status after port reset");
        rchk(0, 5'h12, 32'h0, "R1 pointer after port reset");
        acc(1, 0, 5'h12, 17);
        rchk(0, 5'h10, 32'h0, "R1 generic cleared");
        rchk(0, 5'h14, 32'h0, "R1 word reset port");
        rchk(0, 5'h12, 32'h0, "R1 pointer after word reset");
        idle();
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule